// File: doc/BRIEF.md
# Interlace-Capable Raster Timing Generator

This block produces the horizontal and vertical timing of a video raster from widths that software writes through a simple register port. It drives horizontal sync, vertical sync and a data-enable strobe. It also drives a pixel-request strobe, which honours a pixel repeat factor, and a one-clock field-start pulse that tells an upstream compositor to begin fetching a new field. A level interrupt is raised when the vertical front porch begins. A status output reports whether the block is still producing video.

The block runs in progressive or interlaced mode. In interlaced mode it alternates between two fields. Each field has its own vertical widths. The vertical sync of the odd field can be shifted by a programmed number of pixel clocks, normally half a line. Every setting is copied into shadow registers at a field boundary, so a field that is already being produced never mixes old and new settings. In continuous mode the block runs field after field. In single-shot mode it produces one field and then clears its own run bit.

Top module: `vtime_gen`

## Requirements
- R1: Every line is laid out as sync, back porch, active and front porch, in that order. The sync width is written at address 2 bits [15:0], the back porch at address 2 bits [31:16], the active width at address 3 bits [15:0] and the front porch at address 3 bits [31:16]. The line length is the sum of the four widths, and hsync is high for the first sync-width clocks of each line.
- R2: de is high only where the horizontal active segment and the vertical active lines meet, and never together with hsync.
- R3: A field is laid out vertically as sync, back porch, active and front porch lines. For the odd field, sync is at address 4 [15:0], back porch at 4 [31:16], active at 5 [15:0] and front porch at 5 [31:16]. The field length is the line length times the sum of those four counts.
- R4: Control register bit 1 at address 0 selects interlace. In interlaced mode the fields alternate: odd first, and field is 0 for odd and 1 for even. The even field takes its vertical widths from addresses 6 and 7, which use the same layout as 4 and 5. In progressive mode field stays 0.
- R5: In an interlaced odd field, vsync rises and falls the number of clocks written at address 8 after the line start. In an even field, and in progressive mode, vsync is not delayed.
- R6: Control bits [3:2] at address 0 hold the pixel repeat factor minus one. pix_req pulses on the first clock of each group of that many plus one active clocks, and only while de is high.
- R7: frame_start pulses for exactly one clock on the first clock of every field while the block is running. The first field after the run bit is set is odd.
- R8: The interrupt status sets on the first clock of the vertical front porch. Writing 1 to bit 0 of address 10 clears it. irq equals the status ANDed with bit 0 of address 9.
- R9: Writing 0 to the run bit (address 1 bit 0) lets the current field finish. en_status stays 1 until the clock on which all timing outputs have gone idle.
- R10: A width changed during a field takes effect only from the next field.
- R11: With control bit 0 (continuous) at 0, setting the run bit produces exactly one field, and then the run bit clears itself.
- R12: After reset all outputs are 0 and nothing runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register word address |
| wr_data | input | DW | Register write data |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| de_o | output | 1 | Active video area |
| pix_req_o | output | 1 | Request for a new source pixel |
| frame_start_o | output | 1 | One-clock pulse at the start of each field |
| field_o | output | 1 | 0 for odd field, 1 for even field |
| irq_o | output | 1 | Front-porch interrupt, masked |
| en_status_o | output | 1 | 1 while the run bit is set or video is still being produced |

## Verification
Some properties are checked on every cycle: de and hsync are never high together, pix_req only appears inside de, and frame_start never lasts two clocks. The outputs fall silent the clock after the generator stops, and field stays 0 whenever the shadowed mode is progressive. Writing 1 to the status register clears a pending interrupt on the next clock unless a new one arrives on that same clock. Directed scenarios are needed for the rest: segment lengths and edge positions, the shorter even field, the odd-field vsync delay, the field-boundary latching of new widths, the drain-then-stop handshake and single-shot mode.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  // register word addresses
  localparam int A_CTRL  = 0;
  localparam int A_RUN   = 1;
  localparam int A_HA    = 2;
  localparam int A_HB    = 3;
  localparam int A_VA0   = 4;  // odd set at 4/5, even set at 6/7
  localparam int A_DLY   = 8;
  localparam int A_IRQEN = 9;
  localparam int A_IRQST = 10;
  // field placement inside a data word
  localparam int LO_POS  = 0;
  localparam int HI_POS  = 16;
  // control bits
  localparam int B_CONT  = 0;
  localparam int B_ILACE = 1;
  localparam int B_REP   = 2;
endpackage

// File: rtl/vtg_regs.sv
module vtg_regs import vtg_pkg::*; #(
  parameter int CW = 12,
  parameter int RW = 2,
  parameter int AW = 4,
  parameter int DW = 32,
  parameter int HW = CW + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [DW-1:0]        wr_data,
  input  logic                 irq_set,
  input  logic                 en_clr,
  output logic                 cont,
  output logic                 ilace,
  output logic [RW-1:0]        rep,
  output logic                 vid_en,
  output logic [CW-1:0]        hsw,
  output logic [CW-1:0]        hbp,
  output logic [CW-1:0]        hact,
  output logic [CW-1:0]        hfp,
  output logic [1:0][CW-1:0]   vsw,
  output logic [1:0][CW-1:0]   vbp,
  output logic [1:0][CW-1:0]   vact,
  output logic [1:0][CW-1:0]   vfp,
  output logic [HW-1:0]        dly,
  output logic                 irq_en,
  output logic                 irq_stat
);
  logic clr_hit;
  assign clr_hit = wr_en && (wr_addr == AW'(A_IRQST)) && wr_data[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cont <= 1'b0; ilace <= 1'b0; rep <= '0; vid_en <= 1'b0;
      hsw <= '0; hbp <= '0; hact <= '0; hfp <= '0;
      dly <= '0; irq_en <= 1'b0;
    end else begin
      if (wr_en && wr_addr == AW'(A_CTRL)) begin
        cont  <= wr_data[B_CONT];
        ilace <= wr_data[B_ILACE];
        rep   <= wr_data[B_REP +: RW];
      end
      if (wr_en && wr_addr == AW'(A_RUN)) vid_en <= wr_data[0];
      else if (en_clr)                     vid_en <= 1'b0;
      if (wr_en && wr_addr == AW'(A_HA)) begin
        hsw <= wr_data[LO_POS +: CW];
        hbp <= wr_data[HI_POS +: CW];
      end
      if (wr_en && wr_addr == AW'(A_HB)) begin
        hact <= wr_data[LO_POS +: CW];
        hfp  <= wr_data[HI_POS +: CW];
      end
      if (wr_en && wr_addr == AW'(A_DLY))   dly    <= wr_data[HW-1:0];
      if (wr_en && wr_addr == AW'(A_IRQEN)) irq_en <= wr_data[0];
    end
  end

  // one vertical set per field kind
  for (genvar f = 0; f < 2; f++) begin : g_vset
    always_ff @(posedge clk) begin
      if (rst) begin
        vsw[f] <= '0; vbp[f] <= '0; vact[f] <= '0; vfp[f] <= '0;
      end else if (wr_en) begin
        if (wr_addr == AW'(A_VA0 + 2 * f)) begin
          vsw[f] <= wr_data[LO_POS +: CW];
          vbp[f] <= wr_data[HI_POS +: CW];
        end
        if (wr_addr == AW'(A_VA0 + 2 * f + 1)) begin
          vact[f] <= wr_data[LO_POS +: CW];
          vfp[f]  <= wr_data[HI_POS +: CW];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          irq_stat <= 1'b0;
    else if (irq_set) irq_stat <= 1'b1;
    else if (clr_hit) irq_stat <= 1'b0;
  end

  assert_w1c_R8: assert property (@(posedge clk) disable iff (rst)
    (clr_hit && !irq_set) |=> !irq_stat);
endmodule

// File: rtl/vtg_hline.sv
module vtg_hline #(
  parameter int CW = 12,
  parameter int RW = 2,
  parameter int HW = CW + 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [CW-1:0] hsw,
  input  logic [CW-1:0] hbp,
  input  logic [CW-1:0] hact,
  input  logic [CW-1:0] hfp,
  input  logic [RW-1:0] rep,
  output logic [HW-1:0] hpos,
  output logic          line_end,
  output logic          hs_c,
  output logic          ha_c,
  output logic          req_c
);
  logic [HW-1:0] htot, act_lo, act_hi;
  logic [RW-1:0] rcnt;

  assign htot     = HW'(hsw) + HW'(hbp) + HW'(hact) + HW'(hfp);
  assign act_lo   = HW'(hsw) + HW'(hbp);
  assign act_hi   = act_lo + HW'(hact);
  assign line_end = (hpos == htot - HW'(1));
  assign hs_c     = (hpos < HW'(hsw));
  assign ha_c     = (hpos >= act_lo) && (hpos < act_hi);
  assign req_c    = ha_c && (rcnt == '0);

  always_ff @(posedge clk) begin
    if (rst || !run)   hpos <= '0;
    else if (line_end) hpos <= '0;
    else               hpos <= hpos + HW'(1);
  end

  // position inside the current repeat group
  always_ff @(posedge clk) begin
    if (rst || !run)            rcnt <= '0;
    else if (ha_c && rcnt != rep) rcnt <= rcnt + RW'(1);
    else                        rcnt <= '0;
  end
endmodule

// File: rtl/vtg_vfield.sv
module vtg_vfield #(
  parameter int CW = 12,
  parameter int HW = CW + 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          line_end,
  input  logic [HW-1:0] hpos,
  input  logic [CW-1:0] vsw,
  input  logic [CW-1:0] vbp,
  input  logic [CW-1:0] vact,
  input  logic [CW-1:0] vfp,
  input  logic [HW-1:0] dly,
  output logic [HW-1:0] vpos,
  output logic          field_end,
  output logic          vs_c,
  output logic          va_c,
  output logic          vfp_c
);
  logic [HW-1:0] vtot, act_lo, act_hi, sw;

  assign sw        = HW'(vsw);
  assign vtot      = sw + HW'(vbp) + HW'(vact) + HW'(vfp);
  assign act_lo    = sw + HW'(vbp);
  assign act_hi    = act_lo + HW'(vact);
  assign field_end = line_end && (vpos == vtot - HW'(1));
  assign va_c      = (vpos >= act_lo) && (vpos < act_hi);
  assign vfp_c     = (vpos == act_hi) && (hpos == '0);
  // sync window shifted right by dly clocks
  assign vs_c = ((vpos == '0) && (hpos >= dly)) ||
                ((vpos != '0) && (vpos < sw)) ||
                ((vpos == sw) && (hpos < dly));

  always_ff @(posedge clk) begin
    if (rst || !run)    vpos <= '0;
    else if (field_end) vpos <= '0;
    else if (line_end)  vpos <= vpos + HW'(1);
  end
endmodule

// File: rtl/vtime_gen.sv
module vtime_gen import vtg_pkg::*; #(
  parameter int CW = 12,
  parameter int RW = 2,
  parameter int AW = 4,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic          pix_req_o,
  output logic          frame_start_o,
  output logic          field_o,
  output logic          irq_o,
  output logic          en_status_o
);
  localparam int HW = CW + 2;

  // live register values
  logic                cont, ilace, vid_en, irq_en, irq_stat;
  logic [RW-1:0]       rep;
  logic [CW-1:0]       hsw, hbp, hact, hfp;
  logic [1:0][CW-1:0]  vsw, vbp, vact, vfp;
  logic [HW-1:0]       dly;

  // shadow copies used by the counters
  logic                s_ilace;
  logic [RW-1:0]       s_rep;
  logic [CW-1:0]       s_hsw, s_hbp, s_hact, s_hfp;
  logic [1:0][CW-1:0]  s_vsw, s_vbp, s_vact, s_vfp;
  logic [HW-1:0]       s_dly;

  logic running, field, sel, load, en_clr, irq_set;
  logic [HW-1:0] hpos, vpos, cur_dly;
  logic line_end, hs_c, ha_c, req_c, fend, vs_c, va_c, vfp_c;

  vtg_regs #(.CW(CW), .RW(RW), .AW(AW), .DW(DW), .HW(HW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq_set(irq_set), .en_clr(en_clr), .cont(cont), .ilace(ilace), .rep(rep),
    .vid_en(vid_en), .hsw(hsw), .hbp(hbp), .hact(hact), .hfp(hfp),
    .vsw(vsw), .vbp(vbp), .vact(vact), .vfp(vfp), .dly(dly),
    .irq_en(irq_en), .irq_stat(irq_stat));

  assign sel     = s_ilace & field;
  assign cur_dly = (s_ilace && !field) ? s_dly : '0;

  vtg_hline #(.CW(CW), .RW(RW), .HW(HW)) u_h (
    .clk(clk), .rst(rst), .run(running), .hsw(s_hsw), .hbp(s_hbp),
    .hact(s_hact), .hfp(s_hfp), .rep(s_rep), .hpos(hpos),
    .line_end(line_end), .hs_c(hs_c), .ha_c(ha_c), .req_c(req_c));

  vtg_vfield #(.CW(CW), .HW(HW)) u_v (
    .clk(clk), .rst(rst), .run(running), .line_end(line_end), .hpos(hpos),
    .vsw(s_vsw[sel]), .vbp(s_vbp[sel]), .vact(s_vact[sel]), .vfp(s_vfp[sel]),
    .dly(cur_dly), .vpos(vpos), .field_end(fend), .vs_c(vs_c),
    .va_c(va_c), .vfp_c(vfp_c));

  assign load    = (!running && vid_en) || (running && fend && vid_en && cont);
  assign en_clr  = running && fend && !cont;
  assign irq_set = running && vfp_c;
  assign irq_o   = irq_stat & irq_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      field   <= 1'b0;
    end else if (!running) begin
      if (vid_en) begin
        running <= 1'b1;
        field   <= 1'b0;
      end
    end else if (fend) begin
      if (vid_en && cont) field <= ilace ? ~field : 1'b0;
      else begin
        running <= 1'b0;
        field   <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s_ilace <= 1'b0; s_rep <= '0; s_dly <= '0;
      s_hsw <= '0; s_hbp <= '0; s_hact <= '0; s_hfp <= '0;
      s_vsw <= '0; s_vbp <= '0; s_vact <= '0; s_vfp <= '0;
    end else if (load) begin
      s_ilace <= ilace; s_rep <= rep; s_dly <= dly;
      s_hsw <= hsw; s_hbp <= hbp; s_hact <= hact; s_hfp <= hfp;
      s_vsw <= vsw; s_vbp <= vbp; s_vact <= vact; s_vfp <= vfp;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_o <= 1'b0; vsync_o <= 1'b0; de_o <= 1'b0; pix_req_o <= 1'b0;
      frame_start_o <= 1'b0; field_o <= 1'b0; en_status_o <= 1'b0;
    end else begin
      hsync_o       <= running & hs_c;
      vsync_o       <= running & vs_c;
      de_o          <= running & ha_c & va_c;
      pix_req_o     <= running & req_c & va_c;
      frame_start_o <= running && (hpos == '0) && (vpos == '0);
      field_o       <= running & field;
      en_status_o   <= vid_en | running;
    end
  end

  assert_de_hs_R2: assert property (@(posedge clk) disable iff (rst)
    de_o |-> !hsync_o);
  assert_req_in_de_R6: assert property (@(posedge clk) disable iff (rst)
    pix_req_o |-> de_o);
  assert_fs_single_R7: assert property (@(posedge clk) disable iff (rst)
    frame_start_o |=> !frame_start_o);
  assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !running |=> (!de_o && !frame_start_o && !hsync_o));
  assert_prog_field_R4: assert property (@(posedge clk) disable iff (rst)
    !s_ilace |-> !field);
endmodule

// File: tb/sim_vtime_gen.sv
`timescale 1ns/1ps
module sim_vtime_gen;
  localparam real HALF = 2.5;
  localparam int CAPN = 400;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic hsync_o, vsync_o, de_o, pix_req_o, frame_start_o, field_o, irq_o, en_status_o;

  int checks = 0;
  int errors = 0;
  logic [5:0] cap [0:CAPN-1];  // 0 hs,1 vs,2 de,3 req,4 fs,5 field
  int acc_de = 0, acc_len = 0, last_de = 0, last_len = 0, nfs = 0;

  always #(HALF) clk = ~clk;

  vtime_gen u0 (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
    .pix_req_o(pix_req_o), .frame_start_o(frame_start_o), .field_o(field_o),
    .irq_o(irq_o), .en_status_o(en_status_o));

  // per-field statistics
  always @(negedge clk) begin
    if (frame_start_o) begin
      last_de = acc_de; last_len = acc_len;
      acc_de = de_o ? 1 : 0; acc_len = 1; nfs = nfs + 1;
    end else begin
      acc_de = acc_de + (de_o ? 1 : 0); acc_len = acc_len + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(addr); wr_data = 32'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_fs();
    int n = 0;
    @(negedge clk);
    while (!frame_start_o && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic wait_field();
    int n0 = nfs;
    wait (nfs != n0);
  endtask

  task automatic capture();
    for (int i = 0; i < CAPN; i++) begin
      cap[i] = {field_o, frame_start_o, pix_req_o, de_o, vsync_o, hsync_o};
      if (i != CAPN - 1) @(negedge clk);
    end
  endtask

  function automatic int cnt(input int b, input int lo, input int hi);
    int s = 0;
    for (int i = lo; i < hi; i++) s += cap[i][b];
    return s;
  endfunction

  task automatic t_reset();
    @(negedge clk);
    chk("R12 outputs idle", {hsync_o, vsync_o, de_o, pix_req_o, frame_start_o, field_o, irq_o}, 0);
    chk("R12 en_status", en_status_o, 0);
  endtask

  task automatic t_config();
    wr(2, (3 << 16) | 2);   // hsw 2, hbp 3
    wr(3, (3 << 16) | 8);   // hact 8, hfp 3
    wr(4, (2 << 16) | 2);   // odd vsw 2, vbp 2
    wr(5, (2 << 16) | 4);   // odd vact 4, vfp 2
    wr(6, (1 << 16) | 2);   // even vsw 2, vbp 1
    wr(7, (2 << 16) | 4);
    wr(8, 8);
    wr(9, 1);
  endtask

  task automatic t_progressive();
    wr(0, 1);               // continuous, progressive, no repeat
    wr(1, 1);
    wait_fs();
    capture();
    chk("R7 fs at 0", cap[0][4], 1);
    chk("R7 fs period", cap[160][4], 1);
    chk("R7 fs count", cnt(4, 0, 330), 3);
    chk("R1 hsync width", cnt(0, 0, 16), 2);
    chk("R1 hsync edge", cap[2][0], 0);
    chk("R1 line length", cap[16][0], 1);
    chk("R2 de per field", cnt(2, 0, 160), 32);
    chk("R2 de first", cap[69][2], 1);
    chk("R2 de before", cap[68][2], 0);
    chk("R3 vsync clocks", cnt(1, 0, 160), 32);
    chk("R3 vsync end", cap[32][1], 0);
    chk("R5 progressive no delay", cap[0][1], 1);
    chk("R4 progressive field", cnt(5, 0, 330), 0);
    chk("R6 req no repeat", cnt(3, 0, 160), 32);
  endtask

  task automatic t_irq();
    int k;
    wait_fs();
    wr(10, 1);
    k = 2;
    chk("R8 cleared", irq_o, 0);
    while (!irq_o && k < 400) begin @(negedge clk); k++; end
    chk("R8 irq at front porch", k, 128);
    wr(9, 0);
    chk("R8 masked", irq_o, 0);
    wr(9, 1);
    chk("R8 status kept", irq_o, 1);
    wr(10, 1);
    chk("R8 w1c", irq_o, 0);
  endtask

  task automatic t_shadow();
    wait_fs();
    wr(3, (3 << 16) | 4);   // hact 4 mid-field
    wait_field();
    chk("R10 old de", last_de, 32);
    chk("R10 old len", last_len, 160);
    wait_field();
    chk("R10 new de", last_de, 16);
    chk("R10 new len", last_len, 120);
    wr(3, (3 << 16) | 8);
  endtask

  task automatic t_stop();
    int k, busy;
    wait_fs();
    wait_fs();
    wr(1, 0);
    chk("R9 still busy", en_status_o, 1);
    k = 2;
    while (en_status_o && k < 400) begin @(negedge clk); k++; end
    chk("R9 stop point", k, 160);
    busy = 0;
    for (int i = 0; i < 200; i++) begin
      busy += (de_o | frame_start_o | hsync_o | vsync_o) ? 1 : 0;
      @(negedge clk);
    end
    chk("R9 idle after stop", busy, 0);
  endtask

  task automatic t_interlace();
    wr(0, 7);               // continuous, interlace, repeat 2
    wr(1, 1);
    wait_fs();
    capture();
    chk("R4 odd field", cap[159][5], 0);
    chk("R4 even field", cap[160][5], 1);
    chk("R4 even start", cap[160][4], 1);
    chk("R4 even length", cap[304][4], 1);
    chk("R4 back to odd", cap[304][5], 0);
    chk("R4 even vbp", cap[213][2], 1);
    chk("R4 even vbp before", cap[212][2], 0);
    chk("R5 odd delay low", cap[7][1], 0);
    chk("R5 odd delay rise", cap[8][1], 1);
    chk("R5 odd delay fall", cap[40][1], 0);
    chk("R5 even rise", cap[160][1], 1);
    chk("R5 even fall", cap[192][1], 0);
    chk("R6 req count", cnt(3, 0, 160), 16);
    chk("R6 req first", cap[69][3], 1);
    chk("R6 req gap", cap[70][3], 0);
  endtask

  task automatic t_single();
    int k, f0;
    wr(1, 0);
    k = 0;
    while (en_status_o && k < 800) begin @(negedge clk); k++; end
    wr(0, 0);
    f0 = nfs;
    wr(1, 1);
    for (int i = 0; i < 500; i++) @(negedge clk);
    chk("R11 one field", nfs - f0, 1);
    chk("R11 run cleared", en_status_o, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_config();
    t_progressive();
    t_irq();
    t_shadow();
    t_stop();
    t_interlace();
    t_single();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(2.0 * HALF * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule